// File: doc/BRIEF.md
# Debugger Authentication Gate

This unit sits inside a debug module and decides whether an external debugger may act on the processor. The debugger writes and reads a 32-bit authentication data word; the unit keeps an authenticated flag and a busy flag, drives a grant output that the rest of the debug module uses to allow or refuse debugger requests, and assembles the low byte of the debug-module status word (authenticated, busy, two fixed-zero capability bits and the spec version field).

The built-in mechanism is deliberately simple: bit 0 of the data word is a single read/write bit that is the authenticated flag. A build parameter removes authentication altogether, in which case the debugger is always granted, never busy and the data word reads as zero. A second parameter selects legacy version reporting. A third parameter lets the check take a fixed number of cycles, during which busy is raised and data-word accesses are ignored; at its default of zero the unit is never busy.

Top module: `dbg_auth_unit`

## Requirements
- R1: After reset, with authentication built in, `authenticated`, `grant` and `busy` are 0 and `rd_valid` is 0.
- R2: With zero check latency, a write takes bit 0 of `wr_data` as the new authenticated value on the same clock edge; all other data bits have no effect.
- R3: A write whose bit 0 is 0 clears `authenticated` and `grant`.
- R4: A read raises `rd_valid` for one cycle, one clock after `rd_en`, with `rd_data` = the authenticated bit in bit 0 and zeros in bits 31:1; a read issued together with a write returns the value before the write.
- R5: `dm_reset` clears `authenticated` on the next edge and wins over a write in the same cycle.
- R6: `status_lo` holds authenticated in bit 7, busy in bit 6, zeros in bits 5 and 4, and the version in bits 3:0: 4'b0011 normally, 4'b0010 with legacy reporting.
- R7: With authentication not built in, `authenticated` and `grant` are 1, `busy` is 0, every read returns zero with `rd_valid`, and writes change nothing.
- R8: `grant` is 1 exactly when `authenticated` is 1.
- R9: With check latency N > 0, an accepted write raises `busy` for N cycles and `authenticated` takes the written bit 0 on the edge where `busy` falls; with N = 0 `busy` is never 1.
- R10: While `busy` is 1, writes are dropped and reads produce no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dm_reset | input | 1 | Debug-module reset, drops authentication |
| wr_en | input | 1 | Write strobe for the authentication data word |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe for the authentication data word |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle |
| authenticated | output | 1 | Debugger is authenticated |
| busy | output | 1 | Authentication check in progress |
| grant | output | 1 | Debugger may access the processor |
| status_lo | output | 8 | Low byte of the debug-module status word |

## Verification
Every cycle the assertions check the status byte layout and version code, the forced values when authentication is absent, that a debug-module reset leaves the unit unauthenticated, that zero-latency writes land on the next edge, that reads are dropped while busy and that read data carries nothing above bit 0. Only the bench scenarios show the read-before-write ordering of a combined access, the exact length of the busy window, the delayed arrival of the pending value and the absence of any response to a read refused while busy, which the scoreboard sees as a missing or surplus item.

// File: rtl/dbg_auth_pkg.sv
package dbg_auth_pkg;
  localparam logic [3:0] VER_CURRENT = 4'b0011;
  localparam logic [3:0] VER_LEGACY  = 4'b0010;

  // Layout of the low status byte; bit order is decoded by the debugger.
  typedef struct packed {
    logic       authed;
    logic       busy;
    logic       reset_halt_cap;
    logic       cfg_str_valid;
    logic [3:0] version;
  } status_lo_t;
endpackage

// File: rtl/dbg_auth_core.sv
module dbg_auth_core #(
  parameter int AUTH_EN   = 1,
  parameter int DATA_W    = 32,
  parameter int CHECK_LAT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dm_reset,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              auth,
  output logic              busy
);
  localparam int CNT_W = (CHECK_LAT > 0) ? $clog2(CHECK_LAT + 1) : 1;

  generate
    if (AUTH_EN != 0) begin : g_auth
      logic             auth_q;
      logic             pend_q;
      logic [CNT_W-1:0] cnt_q;
      logic             unused_hi;

      assign unused_hi = ^wr_data[DATA_W-1:1];
      assign auth      = auth_q;
      assign busy      = (cnt_q != '0);

      if (CHECK_LAT == 0) begin : g_direct
        always_ff @(posedge clk) begin
          if (rst || dm_reset) begin
            auth_q <= 1'b0;
          end else if (wr_en) begin
            auth_q <= wr_data[0];
          end
        end
        always_ff @(posedge clk) begin
          cnt_q  <= '0;
          pend_q <= 1'b0;
        end
      end else begin : g_delayed
        always_ff @(posedge clk) begin
          if (rst || dm_reset) begin
            auth_q <= 1'b0;
            pend_q <= 1'b0;
            cnt_q  <= '0;
          end else if (cnt_q == CNT_W'(1)) begin
            auth_q <= pend_q;
            cnt_q  <= '0;
          end else if (cnt_q != '0) begin
            cnt_q  <= cnt_q - CNT_W'(1);
          end else if (wr_en) begin
            pend_q <= wr_data[0];
            cnt_q  <= CNT_W'(CHECK_LAT);
          end
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          rd_valid <= 1'b0;
          rd_data  <= '0;
        end else begin
          rd_valid <= rd_en && !busy;
          if (rd_en && !busy) begin
            rd_data <= {{(DATA_W-1){1'b0}}, auth_q};
          end
        end
      end
    end else begin : g_open
      logic unused_in;
      assign unused_in = ^{dm_reset, wr_en, wr_data};
      assign auth      = 1'b1;
      assign busy      = 1'b0;

      always_ff @(posedge clk) begin
        if (rst) begin
          rd_valid <= 1'b0;
        end else begin
          rd_valid <= rd_en;
        end
        rd_data <= '0;
      end
    end
  endgenerate
endmodule

// File: rtl/dbg_auth_status.sv
module dbg_auth_status
  import dbg_auth_pkg::*;
#(
  parameter int LEGACY_VER = 0
) (
  input  logic       auth,
  input  logic       busy,
  output logic [7:0] status_lo
);
  status_lo_t st;

  always_comb begin
    st.authed         = auth;
    st.busy           = busy;
    st.reset_halt_cap = 1'b0;
    st.cfg_str_valid  = 1'b0;
    st.version        = (LEGACY_VER != 0) ? VER_LEGACY : VER_CURRENT;
  end

  assign status_lo = st;
endmodule

// File: rtl/dbg_auth_unit.sv
module dbg_auth_unit #(
  parameter int AUTH_EN    = 1,
  parameter int LEGACY_VER = 0,
  parameter int DATA_W     = 32,
  parameter int CHECK_LAT  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dm_reset,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              authenticated,
  output logic              busy,
  output logic              grant,
  output logic [7:0]        status_lo
);
  logic auth_w;
  logic busy_w;

  dbg_auth_core #(
    .AUTH_EN  (AUTH_EN),
    .DATA_W   (DATA_W),
    .CHECK_LAT(CHECK_LAT)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .dm_reset(dm_reset),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .rd_valid(rd_valid),
    .auth    (auth_w),
    .busy    (busy_w)
  );

  dbg_auth_status #(
    .LEGACY_VER(LEGACY_VER)
  ) u_status (
    .auth     (auth_w),
    .busy     (busy_w),
    .status_lo(status_lo)
  );

  assign authenticated = auth_w;
  assign busy          = busy_w;
  assign grant         = auth_w;
endmodule

// File: rtl/dbg_auth_chk.sv
module dbg_auth_chk #(
  parameter int AUTH_EN    = 1,
  parameter int LEGACY_VER = 0,
  parameter int DATA_W     = 32,
  parameter int CHECK_LAT  = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              dm_reset,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              authenticated,
  input logic              busy,
  input logic              grant,
  input logic [7:0]        status_lo
);
  localparam logic [3:0] EXP_VER = (LEGACY_VER != 0) ? 4'b0010 : 4'b0011;

  // R6
  status_layout_chk: assert property (@(posedge clk) disable iff (rst)
    status_lo == {authenticated, busy, 2'b00, EXP_VER});

  // R4
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data[DATA_W-1:1] == '0));

  // R10
  busy_read_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_en) |=> !rd_valid);

  // R8
  grant_auth_chk: assert property (@(posedge clk) disable iff (rst)
    grant == authenticated);

  generate
    if (AUTH_EN != 0) begin : g_on
      // R5
      dm_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        dm_reset |=> !authenticated);
      if (CHECK_LAT == 0) begin : g_zl
        // R2
        direct_write_chk: assert property (@(posedge clk) disable iff (rst)
          (wr_en && !dm_reset) |=> (authenticated == $past(wr_data[0])));
        // R9
        never_busy_chk: assert property (@(posedge clk) disable iff (rst)
          !busy);
      end
    end else begin : g_off
      // R7
      open_access_chk: assert property (@(posedge clk) disable iff (rst)
        authenticated && !busy && (!rd_valid || rd_data == '0));
    end
  endgenerate
endmodule

bind dbg_auth_unit dbg_auth_chk #(
  .AUTH_EN   (AUTH_EN),
  .LEGACY_VER(LEGACY_VER),
  .DATA_W    (DATA_W),
  .CHECK_LAT (CHECK_LAT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .dm_reset     (dm_reset),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_en        (rd_en),
  .rd_data      (rd_data),
  .rd_valid     (rd_valid),
  .authenticated(authenticated),
  .busy         (busy),
  .grant        (grant),
  .status_lo    (status_lo)
);

// File: tb/dbg_auth_unit_bench.sv
module dbg_auth_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dm_reset = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        l_wr_en = 1'b0;
  logic [31:0] l_wr_data = '0;
  logic        l_rd_en = 1'b0;

  logic [31:0] rd_data, o_rd_data, l_rd_data;
  logic        rd_valid, o_rd_valid, l_rd_valid;
  logic        authenticated, o_auth, l_auth;
  logic        busy, o_busy, l_busy;
  logic        grant, o_grant, l_grant;
  logic [7:0]  status_lo, o_status, l_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] q_main[$];
  logic [31:0] q_off[$];
  logic [31:0] q_lat[$];

  always #5 clk = ~clk;

  dbg_auth_unit u_dbg_auth_unit (
    .clk(clk), .rst(rst), .dm_reset(dm_reset), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .authenticated(authenticated), .busy(busy), .grant(grant), .status_lo(status_lo));

  dbg_auth_unit #(.AUTH_EN(0), .LEGACY_VER(1)) u_off (
    .clk(clk), .rst(rst), .dm_reset(dm_reset), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(o_rd_data), .rd_valid(o_rd_valid),
    .authenticated(o_auth), .busy(o_busy), .grant(o_grant), .status_lo(o_status));

  dbg_auth_unit #(.CHECK_LAT(3)) u_lat (
    .clk(clk), .rst(rst), .dm_reset(1'b0), .wr_en(l_wr_en), .wr_data(l_wr_data),
    .rd_en(l_rd_en), .rd_data(l_rd_data), .rd_valid(l_rd_valid),
    .authenticated(l_auth), .busy(l_busy), .grant(l_grant), .status_lo(l_status));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pop expected read data as each response appears.
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) begin
        if (q_main.size() == 0) chk("R4 unexpected read", rd_data, 32'hx);
        else chk("R4 read data", rd_data, q_main.pop_front());
      end
      if (o_rd_valid) begin
        if (q_off.size() == 0) chk("R7 unexpected read", o_rd_data, 32'hx);
        else chk("R7 read data", o_rd_data, q_off.pop_front());
      end
      if (l_rd_valid) begin
        if (q_lat.size() == 0) chk("R10 unexpected read", l_rd_data, 32'hx);
        else chk("R10 read data", l_rd_data, q_lat.pop_front());
      end
    end
  end

  // Driver tasks: called at a falling edge, return at the next falling edge.
  task automatic cyc(input logic we, input logic [31:0] wd, input logic re,
                     input logic dr, input logic [31:0] exp_rd);
    wr_en = we; wr_data = wd; rd_en = re; dm_reset = dr;
    if (re) begin
      q_main.push_back(exp_rd);
      q_off.push_back(32'h0);
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; dm_reset = 1'b0;
  endtask

  task automatic lcyc(input logic we, input logic [31:0] wd, input logic re,
                      input logic accept_rd, input logic [31:0] exp_rd);
    l_wr_en = we; l_wr_data = wd; l_rd_en = re;
    if (re && accept_rd) q_lat.push_back(exp_rd);
    @(negedge clk);
    l_wr_en = 1'b0; l_rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 auth", {31'b0, authenticated}, 32'h0);
    chk("R1 grant", {31'b0, grant}, 32'h0);
    chk("R1 busy", {31'b0, busy}, 32'h0);
    chk("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
    chk("R6 status current", {24'b0, status_lo}, 32'h03);
    chk("R6 status legacy", {24'b0, o_status}, 32'h82);
    chk("R7 open auth", {30'b0, o_auth, o_grant}, 32'h3);
    chk("R9 lat idle busy", {31'b0, l_busy}, 32'h0);

    cyc(1'b0, 32'h0, 1'b1, 1'b0, 32'h0);                 // R4 read when clear
    cyc(1'b1, 32'hFFFF_FFFE, 1'b0, 1'b0, 32'h0);         // R2 upper bits only
    chk("R2 upper bits ignored", {31'b0, authenticated}, 32'h0);
    cyc(1'b1, 32'h0000_0001, 1'b0, 1'b0, 32'h0);
    chk("R2 authenticate", {31'b0, authenticated}, 32'h1);
    chk("R8 grant follows", {31'b0, grant}, 32'h1);
    chk("R6 status authed", {24'b0, status_lo}, 32'h83);
    cyc(1'b0, 32'h0, 1'b1, 1'b0, 32'h1);                 // R4 reads 1, not all ones
    cyc(1'b1, 32'h0, 1'b1, 1'b0, 32'h1);                 // R4 old value on combined access
    chk("R3 deauthenticate", {31'b0, authenticated}, 32'h0);
    chk("R3 grant drops", {31'b0, grant}, 32'h0);
    chk("R7 write ignored", {30'b0, o_auth, o_busy}, 32'h2);
    cyc(1'b1, 32'h1, 1'b0, 1'b0, 32'h0);
    cyc(1'b1, 32'h1, 1'b0, 1'b1, 32'h0);                 // R5 reset beats write
    chk("R5 reset wins", {31'b0, authenticated}, 32'h0);
    cyc(1'b1, 32'h1, 1'b0, 1'b0, 32'h0);
    cyc(1'b0, 32'h0, 1'b0, 1'b1, 32'h0);
    chk("R5 reset clears", {31'b0, authenticated}, 32'h0);
    cyc(1'b0, 32'h0, 1'b1, 1'b0, 32'h0);

    // R9 / R10 latency instance, N = 3
    lcyc(1'b1, 32'h1, 1'b0, 1'b0, 32'h0);
    chk("R9 busy after write", {30'b0, l_busy, l_auth}, 32'h2);
    chk("R6 status busy", {24'b0, l_status}, 32'h43);
    lcyc(1'b1, 32'h0, 1'b1, 1'b0, 32'h0);                // R10 dropped
    chk("R9 busy cycle 2", {30'b0, l_busy, l_auth}, 32'h2);
    lcyc(1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
    chk("R9 busy cycle 3", {30'b0, l_busy, l_auth}, 32'h2);
    lcyc(1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
    chk("R9 lands as busy falls", {30'b0, l_busy, l_auth}, 32'h1);
    lcyc(1'b0, 32'h0, 1'b1, 1'b1, 32'h1);                // R10 dropped write left auth set
    repeat (3) @(negedge clk);
    chk("R10 no stray responses", q_main.size() + q_off.size() + q_lat.size(), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule